// File: doc/BRIEF.md
# Keyed embedded flash controller

This block sits between a simple register bus and a small on-chip non-volatile word array. The array has a main region made of several pages and a separate one-page info region. Software does not issue high-level commands. It moves the array's control strobes one step at a time by writing a command register. A key register guards every change to that command register.

The controller watches each accepted command write and compares the old strobe pattern with the new one. Erase and word programming happen only when the strobes arrive in the fixed order. A read takes effect while the read strobes are held. Any strobe that arrives out of order raises a sticky sequence-error flag and leaves the array untouched.

The array itself is behavioural. An erased word reads as all ones, and programming can only clear bits. Timing fields are stored and read back but do not stretch any operation.

Top module: `keyed_flash_ctrl`

## Requirements
- R1: After reset the command register reads 0, the controller is locked, the sequence-error flag is 0, the data-out register reads 0 and every array word in both regions holds 32'hFFFFFFFF.
- R2: Register byte offsets are command 0x00, address 0x04, data-in 0x08, data-out 0x0C and key 0x10. Read data appears on the cycle after the read-enable cycle. The key reads as 0, and an unmapped offset reads as 0.
- R3: A write to the command register is accepted only while the key register holds 32'h8AAA5551. Writing any other value to the key, including 0, locks the controller again, and a locked command write leaves the command register and the array unchanged.
- R4: Command bits are enable=0, wr=1, rd=2, timing field [5:3], row select=6, column strobe=7, sense=8, info select=9, erase=10, mass=11, program=12 and high-voltage=13. Bits 31:14 are stored as 0.
- R5: While enable, row select, column strobe and sense are all set, data-out returns the word at the loaded address, taken from the info region when info select is set. Once that mode is left, data-out keeps the last word it returned.
- R6: A sector erase happens on the accepted write that raises high-voltage while row select and erase are set in both the old and the new value, program is clear and enable is set. It sets to all ones every word of the addressed page whose column matches the address.
- R7: If mass is set in that same write, the erase covers the addressed column in every page of the selected region.
- R8: A word is programmed on the accepted write that raises the column strobe while row select, program and high-voltage were already set and remain set, with enable set and erase and sense clear. The new word is the bitwise AND of the old word and data-in.
- R9: Address bits [3:2] give the sector column, and the word index is address bits [7:2]. A main-region page is 16 words, so the page is word index / 16. The info region is 16 words and uses address bits [5:2].
- R10: A rising column strobe that is neither a program pulse nor part of a read pattern, a rising high-voltage that neither starts an erase nor arms programming, or erase and program set together, sets a sequence-error flag. The flag stays set until reset, and the array is not changed by that write.
- R11: A command write that keeps only the timing field returns the array to idle. Reading the command register back returns just that timing value, and no operation takes place.
- R12: Program and erase with info select set change only the info region, and the same main-region address is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable |
| reg_re | input | 1 | Read enable |
| reg_rdata | output | 32 | Read data, registered |
| seq_err | output | 1 | Sticky sequence-error flag |

## Verification
The bench checks whether erase fires only when high-voltage rises with erase already held from an earlier write. A design that accepts both in the same write would erase on a bad sequence and would raise no error. The bench erases one column of one page and checks that the neighbouring columns and pages keep their programmed values. A design that decodes the page or the column wrongly would wipe words it should spare, or would leave some of the addressed words in place. It programs the same word twice to show the AND behaviour, and it checks that info-region operations leave the main region alone. It also writes the command register while locked and after relocking, to show that a missing key check corrupts the command state.

// File: rtl/kfc_pkg.sv
package kfc_pkg;

    localparam logic [31:0] UNLOCK_WORD = 32'h8AAA5551;

    localparam logic [4:0] OFS_CMD  = 5'h00;
    localparam logic [4:0] OFS_ADDR = 5'h04;
    localparam logic [4:0] OFS_DIN  = 5'h08;
    localparam logic [4:0] OFS_DOUT = 5'h0C;
    localparam logic [4:0] OFS_KEY  = 5'h10;

    localparam int CMD_USED_BITS = 14;

    typedef struct packed {
        logic [17:0] rsv;
        logic        hv;       // 13
        logic        prog;     // 12
        logic        mass;     // 11
        logic        erase;    // 10
        logic        info;     // 9
        logic        sense;    // 8
        logic        col_stb;  // 7
        logic        row_sel;  // 6
        logic [2:0]  timing;   // 5:3
        logic        rd;       // 2
        logic        wr;       // 1
        logic        en;       // 0
    } cmd_t;

    typedef struct packed {
        logic erase_go;
        logic prog_go;
        logic mass;
        logic info;
    } op_t;

    function automatic logic read_mode(cmd_t c);
        return c.en & c.row_sel & c.col_stb & c.sense;
    endfunction

    function automatic cmd_t to_cmd(logic [31:0] w);
        cmd_t c;
        c = cmd_t'({18'b0, w[CMD_USED_BITS-1:0]});
        return c;
    endfunction

endpackage

// File: rtl/kfc_regs.sv
module kfc_regs
    import kfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_we,
    output cmd_t        cmd_q,
    output cmd_t        cmd_new,
    output logic        cmd_acc,
    output logic [31:0] addr_q,
    output logic [31:0] din_q
);
    logic [31:0] key_q;
    logic        unlocked;

    assign unlocked = (key_q == UNLOCK_WORD);
    assign cmd_new  = to_cmd(reg_wdata);
    assign cmd_acc  = reg_we && (reg_addr == OFS_CMD) && unlocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q  <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            if (reg_we && reg_addr == OFS_KEY)  key_q  <= reg_wdata;
            if (reg_we && reg_addr == OFS_ADDR) addr_q <= reg_wdata;
            if (reg_we && reg_addr == OFS_DIN)  din_q  <= reg_wdata;
            if (cmd_acc)                        cmd_q  <= cmd_new;
        end
    end

    // R3: locked command writes leave the command register alone
    a_r3_locked_cmd_stable: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_CMD && !unlocked) |=> $stable(cmd_q));

endmodule

// File: rtl/kfc_seq.sv
module kfc_seq
    import kfc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_acc,
    input  cmd_t cmd_old,
    input  cmd_t cmd_new,
    output op_t  op,
    output logic seq_err
);
    logic hv_rise, ye_rise;
    logic erase_ok, prog_ok, prog_arm, read_pat;
    logic err_ye, err_hv, err_both, err_set;

    assign hv_rise = !cmd_old.hv && cmd_new.hv;
    assign ye_rise = !cmd_old.col_stb && cmd_new.col_stb;

    always_comb begin
        erase_ok = hv_rise && cmd_new.en
                && cmd_old.row_sel && cmd_old.erase && !cmd_old.prog
                && cmd_new.row_sel && cmd_new.erase && !cmd_new.prog;
        prog_arm = hv_rise && cmd_new.en
                && cmd_old.row_sel && cmd_old.prog
                && cmd_new.row_sel && cmd_new.prog && !cmd_new.erase;
        prog_ok  = ye_rise && cmd_new.en
                && cmd_old.row_sel && cmd_old.prog && cmd_old.hv
                && cmd_new.row_sel && cmd_new.prog && cmd_new.hv
                && !cmd_new.erase && !cmd_new.sense;
        read_pat = cmd_new.en && cmd_new.row_sel && cmd_new.sense;
        err_ye   = ye_rise && !prog_ok && !read_pat;
        err_hv   = hv_rise && !erase_ok && !prog_arm;
        err_both = cmd_new.erase && cmd_new.prog;
        err_set  = cmd_acc && (err_ye || err_hv || err_both);
    end

    always_comb begin
        op.erase_go = cmd_acc && erase_ok && !err_set;
        op.prog_go  = cmd_acc && prog_ok && !err_set;
        op.mass     = cmd_new.mass;
        op.info     = cmd_new.info;
    end

    always_ff @(posedge clk) begin
        if (rst)          seq_err <= 1'b0;
        else if (err_set) seq_err <= 1'b1;
    end

    // R10: the error flag is sticky until reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

endmodule

// File: rtl/kfc_array.sv
module kfc_array #(
    parameter int PAGE_COUNT = 4,
    parameter int PAGE_WORDS = 16,
    parameter int INFO_PAGES = 1,
    localparam int MAIN_WORDS = PAGE_COUNT * PAGE_WORDS,
    localparam int INFO_WORDS = INFO_PAGES * PAGE_WORDS,
    localparam int MW_W       = $clog2(MAIN_WORDS),
    localparam int IW_W       = $clog2(INFO_WORDS),
    localparam int COLS       = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            erase_go,
    input  logic            prog_go,
    input  logic            mass,
    input  logic            op_info,
    input  logic            rd_info,
    input  logic [MW_W-1:0] widx,
    input  logic [31:0]     pdata,
    output logic [31:0]     rd_word
);
    logic [31:0] main_mem [MAIN_WORDS];
    logic [31:0] info_mem [INFO_WORDS];
    logic [IW_W-1:0] iidx;
    int col, mpage, ipage;

    assign iidx  = widx[IW_W-1:0];
    assign col   = int'(widx[1:0]);
    assign mpage = int'(widx) / PAGE_WORDS;
    assign ipage = int'(iidx) / PAGE_WORDS;
    assign rd_word = rd_info ? info_mem[iidx] : main_mem[widx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < MAIN_WORDS; j++) main_mem[j] <= '1;
            for (int j = 0; j < INFO_WORDS; j++) info_mem[j] <= '1;
        end else if (erase_go) begin
            if (op_info) begin
                for (int j = 0; j < INFO_WORDS; j++)
                    if ((j % COLS) == col && (mass || (j / PAGE_WORDS) == ipage))
                        info_mem[j] <= '1;
            end else begin
                for (int j = 0; j < MAIN_WORDS; j++)
                    if ((j % COLS) == col && (mass || (j / PAGE_WORDS) == mpage))
                        main_mem[j] <= '1;
            end
        end else if (prog_go) begin
            if (op_info) info_mem[iidx] <= info_mem[iidx] & pdata;
            else         main_mem[widx] <= main_mem[widx] & pdata;
        end
    end

    // R8: programming only clears bits of the addressed word
    a_r8_prog_and: assert property (@(posedge clk) disable iff (rst)
        (prog_go && !op_info) |=>
            main_mem[$past(widx)] == ($past(main_mem[widx]) & $past(pdata)));

    // R6: the addressed word is always inside an erase
    a_r6_erase_ones: assert property (@(posedge clk) disable iff (rst)
        (erase_go && !op_info) |=> main_mem[$past(widx)] == 32'hFFFF_FFFF);

endmodule

// File: rtl/keyed_flash_ctrl.sv
module keyed_flash_ctrl
    import kfc_pkg::*;
#(
    parameter int PAGE_COUNT = 4,
    parameter int PAGE_WORDS = 16,
    parameter int INFO_PAGES = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_we,
    input  logic        reg_re,
    output logic [31:0] reg_rdata,
    output logic        seq_err
);
    localparam int MW_W = $clog2(PAGE_COUNT * PAGE_WORDS);

    cmd_t        cmd_q, cmd_new;
    logic        cmd_acc;
    logic [31:0] addr_q, din_q, rd_word, dout_q;
    op_t         op;
    logic        in_read;

    kfc_regs u_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .cmd_q(cmd_q), .cmd_new(cmd_new), .cmd_acc(cmd_acc),
        .addr_q(addr_q), .din_q(din_q)
    );

    kfc_seq u_seq (
        .clk(clk), .rst(rst), .cmd_acc(cmd_acc), .cmd_old(cmd_q),
        .cmd_new(cmd_new), .op(op), .seq_err(seq_err)
    );

    kfc_array #(
        .PAGE_COUNT(PAGE_COUNT), .PAGE_WORDS(PAGE_WORDS), .INFO_PAGES(INFO_PAGES)
    ) u_array (
        .clk(clk), .rst(rst), .erase_go(op.erase_go), .prog_go(op.prog_go),
        .mass(op.mass), .op_info(op.info), .rd_info(cmd_q.info),
        .widx(addr_q[MW_W+1:2]), .pdata(din_q), .rd_word(rd_word)
    );

    assign in_read = read_mode(cmd_q);

    always_ff @(posedge clk) begin
        if (rst)          dout_q <= '0;
        else if (in_read) dout_q <= rd_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_re) begin
            case (reg_addr)
                OFS_CMD:  reg_rdata <= cmd_q;
                OFS_ADDR: reg_rdata <= addr_q;
                OFS_DIN:  reg_rdata <= din_q;
                OFS_DOUT: reg_rdata <= in_read ? rd_word : dout_q;
                default:  reg_rdata <= '0;
            endcase
        end
    end

    // R5: data-out tracks the addressed word while in read mode
    a_r5_dout_follows: assert property (@(posedge clk) disable iff (rst)
        in_read |=> dout_q == $past(rd_word));

    // R5: data-out holds when read mode is off
    a_r5_dout_holds: assert property (@(posedge clk) disable iff (rst)
        !in_read |=> $stable(dout_q));

endmodule

// File: tb/keyed_flash_ctrl_tb.sv
module keyed_flash_ctrl_tb_top;
    localparam logic [31:0] KEYV = 32'h8AAA5551;
    localparam logic [31:0] B_EN = 32'h1, B_ROW = 32'h40, B_COL = 32'h80,
        B_SNS = 32'h100, B_INF = 32'h200, B_ERS = 32'h400, B_MAS = 32'h800,
        B_PRG = 32'h1000, B_HV = 32'h2000;

    logic clk = 0, rst = 1, reg_we = 0, reg_re = 0;
    logic [4:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic seq_err;
    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    logic [31:0] m_main[64], m_info[16];
    logic [31:0] m_cmd, m_addr, m_di, m_key, m_dout;
    bit m_err;

    always #10 clk = ~clk;

    keyed_flash_ctrl dut_i (.clk(clk), .rst(rst), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .seq_err(seq_err));

    function automatic bit rmode(logic [31:0] c);
        return c[0] & c[6] & c[7] & c[8];
    endfunction

    function automatic logic [31:0] word_at(logic [31:0] a, bit inf);
        return inf ? m_info[(a >> 2) & 15] : m_main[(a >> 2) & 63];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_main[i] = '1;
        for (int i = 0; i < 16; i++) m_info[i] = '1;
        m_cmd = 0; m_addr = 0; m_di = 0; m_key = 0; m_dout = 0; m_err = 0;
    endtask

    task automatic model_cmd(logic [31:0] w);
        logic [31:0] o, n;
        bit hvr, yer, ers, prg, arm, rdp, err;
        int col, pg;
        if (m_key != KEYV) return;
        o = m_cmd; n = w & 32'h3FFF;
        hvr = !o[13] && n[13];
        yer = !o[7] && n[7];
        ers = hvr && n[0] && o[6] && o[10] && !o[12] && n[6] && n[10] && !n[12];
        arm = hvr && n[0] && o[6] && o[12] && n[6] && n[12] && !n[10];
        prg = yer && n[0] && o[6] && o[12] && o[13] && n[6] && n[12] && n[13] && !n[10] && !n[8];
        rdp = n[0] && n[6] && n[8];
        err = (yer && !prg && !rdp) || (hvr && !ers && !arm) || (n[10] && n[12]);
        col = (m_addr >> 2) & 3;
        if (err) m_err = 1;
        else if (ers) begin
            if (n[9]) begin
                for (int i = 0; i < 16; i++) if ((i % 4) == col) m_info[i] = '1;
            end else begin
                pg = ((m_addr >> 2) & 63) / 16;
                for (int i = 0; i < 64; i++)
                    if ((i % 4) == col && (n[11] || i / 16 == pg)) m_main[i] = '1;
            end
        end else if (prg) begin
            if (n[9]) m_info[(m_addr >> 2) & 15] &= m_di;
            else      m_main[(m_addr >> 2) & 63] &= m_di;
        end
        m_cmd = n;
    endtask

    task automatic post_op();
        if (rmode(m_cmd)) m_dout = word_at(m_addr, m_cmd[9]);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
        @(posedge clk);
        case (a)
            5'h00: model_cmd(d);
            5'h04: m_addr = d;
            5'h08: m_di = d;
            5'h10: m_key = d;
            default: ;
        endcase
        post_op();
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(logic [4:0] a, string tag);
        logic [31:0] exp;
        @(negedge clk); reg_addr = a; reg_re = 1;
        case (a)
            5'h00: exp = m_cmd;
            5'h04: exp = m_addr;
            5'h08: exp = m_di;
            5'h0C: exp = rmode(m_cmd) ? word_at(m_addr, m_cmd[9]) : m_dout;
            default: exp = 0;
        endcase
        @(posedge clk); post_op();
        @(negedge clk); reg_re = 0;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s offset %h actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic rd_word(logic [31:0] a, bit inf, string tag);
        logic [31:0] base;
        base = B_EN | (inf ? B_INF : 0);
        wr(5'h04, a);
        wr(5'h00, base | B_ROW | B_COL | B_SNS);
        rd(5'h0C, tag);
        wr(5'h00, base);
    endtask

    task automatic prog_word(logic [31:0] a, logic [31:0] d, bit inf);
        logic [31:0] base;
        base = B_EN | (inf ? B_INF : 0);
        wr(5'h04, a);
        wr(5'h00, base | B_ROW | B_PRG);
        wr(5'h00, base | B_ROW | B_PRG | B_HV);
        wr(5'h08, d);
        wr(5'h04, a);
        wr(5'h00, base | B_ROW | B_PRG | B_HV | B_COL);
        wr(5'h00, base | B_ROW | B_PRG | B_HV);
        wr(5'h00, base | B_ROW | B_PRG);
        wr(5'h00, base);
    endtask

    task automatic erase_col(logic [31:0] a, bit mas, bit inf);
        logic [31:0] base;
        base = B_EN | (inf ? B_INF : 0) | (mas ? B_MAS : 0);
        wr(5'h04, a);
        wr(5'h00, base | B_ROW | B_ERS);
        wr(5'h00, base | B_ROW | B_ERS | B_HV);
        wr(5'h00, base | B_ROW | B_HV);
        wr(5'h00, B_EN | (inf ? B_INF : 0));
    endtask

    // R10: error flag compared against the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (seq_err !== m_err) begin
                errors++;
                $display("FAIL R10 seq_err actual %0d expected %0d", seq_err, m_err);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1; errors++;
            $display("FAIL watchdog actual %0d expected <100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(5'h00, "R1 cmd");
        rd(5'h0C, "R1 dout");
        // R3 locked write ignored
        wr(5'h00, B_EN | B_ROW);
        rd(5'h00, "R3 locked");
        wr(5'h10, KEYV);
        // R2 offsets and readback
        rd(5'h10, "R2 key hidden");
        wr(5'h04, 32'h24); rd(5'h04, "R2 addr");
        wr(5'h08, 32'hA5A5_0F0F); rd(5'h08, "R2 din");
        rd(5'h14, "R2 unmapped");
        // R4 bit positions and unused upper bits
        wr(5'h00, 32'hFFFF_0000 | B_EN | 32'h2 | 32'h4);
        rd(5'h00, "R4 cmd bits");
        wr(5'h00, B_EN);
        rd_word(32'h24, 0, "R1 erased");
        // R8 program, then AND
        prog_word(32'h14, 32'h1234_5678, 0);
        rd_word(32'h14, 0, "R8 program");
        prog_word(32'h14, 32'hFF00_FFFF, 0);
        rd_word(32'h14, 0, "R8 and");
        // R5 dout holds after read mode
        rd(5'h0C, "R5 hold");
        // R6/R9 sector erase
        prog_word(32'h44, 32'h0, 0);
        prog_word(32'h54, 32'h0, 0);
        prog_word(32'h48, 32'h1, 0);
        prog_word(32'h84, 32'h2, 0);
        erase_col(32'h44, 0, 0);
        rd_word(32'h54, 0, "R6 same column erased");
        rd_word(32'h48, 0, "R9 other column kept");
        rd_word(32'h84, 0, "R6 other page kept");
        // R7 mass erase of column 1
        erase_col(32'h04, 1, 0);
        rd_word(32'h84, 0, "R7 mass erased");
        rd_word(32'h48, 0, "R7 column 2 kept");
        // R12 info region
        prog_word(32'h08, 32'h0000_00FF, 1);
        rd_word(32'h08, 1, "R12 info programmed");
        rd_word(32'h08, 0, "R12 main untouched");
        erase_col(32'h08, 0, 1);
        rd_word(32'h08, 1, "R12 info erased");
        // R11 timing-only write
        wr(5'h00, B_EN | B_ROW | (32'd5 << 3));
        wr(5'h00, 32'd5 << 3);
        rd(5'h00, "R11 timing kept");
        // R10 out-of-order strobes
        prog_word(32'h18, 32'h0, 0);
        wr(5'h00, B_EN | B_COL);
        wr(5'h00, B_EN);
        wr(5'h00, B_EN | B_ROW | B_ERS | B_HV);
        wr(5'h00, B_EN);
        rd_word(32'h18, 0, "R10 no erase on bad order");
        // R3 relock
        wr(5'h10, 32'h0);
        wr(5'h00, B_EN | B_ROW | B_COL | B_SNS);
        rd(5'h00, "R3 relocked");
        // R1 reset clears error flag
        @(negedge clk); rst = 1; model_reset();
        @(negedge clk); rst = 0;
        rd(5'h00, "R1 after reset");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule